// File: doc/BRIEF.md
# Paged Memory Address Unit

This block forms the 16-bit RAM address for a small processor that does its arithmetic through lookup tables held in memory. The address has two bytes. The high byte is either a page register or a fixed default page. The low byte comes from one of three index registers, or from a fixed default offset. The address is built without a real multiplexer: a byte that no source drives falls to the default value. Under the 0x00 variant this acts like pull-down resistors, and under the 0xFF variant like pull-ups. As a result, the location at [default,default] can always be reached without loading anything, and it serves as a spare storage cell.

The index register x can be loaded as a full byte or one nibble at a time. It also has an increment strobe, so that a run of bytes can be read at one per cycle to feed pixel output. The registers u and v are plain byte registers and are used as nibble-paired lookup indices. All registers load from the shared data bus.

If more than one low-byte source is enabled in a cycle, the block drives the source with the highest priority and raises a sticky error flag.

Top module: `mau_addr_unit`

## Requirements
- R1: addr_o[15:8] equals the page register when en_y_i is high and equals the default byte when en_y_i is low.
- R2: addr_o[7:0] equals x when en_x_i is high, u when en_u_i is high, or v when en_v_i is high (one enable at a time). It equals the default byte when none of these enables is high.
- R3: The default byte is 0x00 when parameter DEF_ONES is 0 and 0xFF when DEF_ONES is 1. With no enables active, addr_o equals {default, default}.
- R4: A pulse on ld_x_i, ld_u_i, ld_v_i or ld_y_i copies bus_i into the matching register, and the new value is visible on addr_o from the next cycle.
- R5: A pulse on inc_x_i adds one to x, wrapping from 0xFF to 0x00. The page register is never changed by this.
- R6: ld_xlo_i writes bus_i[3:0] into x[3:0] and leaves x[7:4] unchanged. ld_xhi_i writes bus_i[7:4] into x[7:4] and leaves x[3:0] unchanged.
- R7: When any x load strobe (full or nibble) is active in the same cycle as inc_x_i, the load takes effect and the increment is dropped.
- R8: When two or more of en_x_i, en_u_i and en_v_i are high, the low byte follows the priority order x, then u, then v. err_o rises on the next clock edge and stays high until reset.
- R9: After reset, all four registers hold 0x00 and err_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| bus_i | input | 8 | data bus feeding all register loads |
| ld_x_i | input | 1 | load full byte into x |
| ld_xlo_i | input | 1 | load low nibble of x |
| ld_xhi_i | input | 1 | load high nibble of x |
| inc_x_i | input | 1 | increment x |
| ld_u_i | input | 1 | load u |
| ld_v_i | input | 1 | load v |
| ld_y_i | input | 1 | load page register |
| en_y_i | input | 1 | drive page register onto high byte |
| en_x_i | input | 1 | drive x onto low byte |
| en_u_i | input | 1 | drive u onto low byte |
| en_v_i | input | 1 | drive v onto low byte |
| addr_o | output | 16 | RAM address |
| err_o | output | 1 | sticky multiple-enable error |

## Verification
The bench sweeps all 256 values through every register and checks them against both default variants. A design that confused pull-up with pull-down would show the wrong undriven byte under one of the two instances. The increment test starts from 0xFE. A design that carried into the page register, or that saturated instead of wrapping, would show a wrong page or a stuck 0xFF. The bench also applies a nibble load and an increment together; a design that ignored the untouched half, or that honoured the increment, would return a mixed value. Finally, the bench enables two sources at once. A design with the wrong priority order, or with a flag that is not sticky, would drive the wrong index or drop err_o one cycle later.

// File: rtl/mau_pkg.sv
package mau_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;
  localparam int unsigned ADDR_W = 2 * BYTE_W;
  localparam int unsigned N_LO   = 3;  // low-byte sources, priority order: x, u, v

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t default_byte(input bit ones);
    return ones ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
  endfunction
endpackage

// File: rtl/mau_byte_reg.sv
module mau_byte_reg
  import mau_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ld_i,
  input  byte_t d_i,
  output byte_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q_o == $past(d_i));
endmodule

// File: rtl/mau_x_index.sv
module mau_x_index
  import mau_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  byte_t bus_i,
  input  logic  ld_i,
  input  logic  ld_lo_i,
  input  logic  ld_hi_i,
  input  logic  inc_i,
  output byte_t x_o
);
  logic  any_ld;
  byte_t x_next;

  assign any_ld = ld_i | ld_lo_i | ld_hi_i;

  always_comb begin
    x_next = x_o;
    if (any_ld) begin
      if (ld_i || ld_lo_i) x_next[NIB_W-1:0]      = bus_i[NIB_W-1:0];
      if (ld_i || ld_hi_i) x_next[BYTE_W-1:NIB_W] = bus_i[BYTE_W-1:NIB_W];
    end else if (inc_i) begin
      x_next = x_o + byte_t'(1);  // wraps, no carry out
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) x_o <= '0;
    else         x_o <= x_next;
  end

  p_inc_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !any_ld) |=> x_o == byte_t'($past(x_o) + 8'd1));
  p_load_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && inc_i) |=> x_o == $past(bus_i));
  p_lo_keeps_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo_i && !ld_i && !ld_hi_i) |=> x_o[BYTE_W-1:NIB_W] == $past(x_o[BYTE_W-1:NIB_W]));
endmodule

// File: rtl/mau_low_sel.sv
module mau_low_sel
  import mau_pkg::*;
#(
  parameter bit DEF_ONES = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_LO-1:0] en_i,
  input  byte_t           src_i [N_LO],
  output byte_t           lo_o,
  output logic            err_o
);
  logic multi;

  assign multi = $countones(en_i) > 1;

  always_comb begin
    lo_o = default_byte(DEF_ONES);
    for (int i = N_LO - 1; i >= 0; i--) begin
      if (en_i[i]) lo_o = src_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_o <= 1'b0;
    else if (multi) err_o <= 1'b1;
  end

  p_err_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi |=> err_o);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_top_prio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i[0] |-> lo_o == src_i[0]);
endmodule

// File: rtl/mau_addr_unit.sv
module mau_addr_unit
  import mau_pkg::*;
#(
  parameter bit DEF_ONES = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  bus_i,
  input  logic        ld_x_i,
  input  logic        ld_xlo_i,
  input  logic        ld_xhi_i,
  input  logic        inc_x_i,
  input  logic        ld_u_i,
  input  logic        ld_v_i,
  input  logic        ld_y_i,
  input  logic        en_y_i,
  input  logic        en_x_i,
  input  logic        en_u_i,
  input  logic        en_v_i,
  output logic [15:0] addr_o,
  output logic        err_o
);
  localparam byte_t DEF = default_byte(DEF_ONES);

  byte_t x_q, y_q, lo;
  byte_t regs_q [N_LO];  // 0:x 1:u 2:v
  logic [N_LO-1:0] lo_ld, lo_en;

  assign lo_ld = {ld_v_i, ld_u_i, 1'b0};
  assign lo_en = {en_v_i, en_u_i, en_x_i};

  mau_x_index i_x (
    .clk_i, .rst_ni, .bus_i,
    .ld_i(ld_x_i), .ld_lo_i(ld_xlo_i), .ld_hi_i(ld_xhi_i), .inc_i(inc_x_i),
    .x_o(x_q)
  );
  assign regs_q[0] = x_q;

  for (genvar g = 1; g < N_LO; g++) begin : g_idx
    mau_byte_reg i_reg (
      .clk_i, .rst_ni, .ld_i(lo_ld[g]), .d_i(bus_i), .q_o(regs_q[g])
    );
  end

  mau_byte_reg i_y (
    .clk_i, .rst_ni, .ld_i(ld_y_i), .d_i(bus_i), .q_o(y_q)
  );

  mau_low_sel #(.DEF_ONES(DEF_ONES)) i_sel (
    .clk_i, .rst_ni, .en_i(lo_en), .src_i(regs_q), .lo_o(lo), .err_o
  );

  assign addr_o = {en_y_i ? y_q : DEF, lo};

  p_hi_default_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_y_i |-> addr_o[15:8] == DEF);
  p_spare_cell_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_y_i && lo_en == '0) |-> addr_o == {DEF, DEF});
  p_inc_keeps_y_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_x_i && !ld_y_i) |=> $stable(y_q));
endmodule

// File: tb/test_mau_addr_unit.sv
module test_mau_addr_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus = '0;
  logic ld_x = 0, ld_xlo = 0, ld_xhi = 0, inc_x = 0, ld_u = 0, ld_v = 0, ld_y = 0;
  logic en_y = 0, en_x = 0, en_u = 0, en_v = 0;
  logic [15:0] a0, a1;
  logic e0, e1;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  mau_addr_unit #(.DEF_ONES(1'b0)) i_mau_addr_unit (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .ld_x_i(ld_x), .ld_xlo_i(ld_xlo),
    .ld_xhi_i(ld_xhi), .inc_x_i(inc_x), .ld_u_i(ld_u), .ld_v_i(ld_v), .ld_y_i(ld_y),
    .en_y_i(en_y), .en_x_i(en_x), .en_u_i(en_u), .en_v_i(en_v), .addr_o(a0), .err_o(e0));
  mau_addr_unit #(.DEF_ONES(1'b1)) i_mau_addr_unit_ff (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .ld_x_i(ld_x), .ld_xlo_i(ld_xlo),
    .ld_xhi_i(ld_xhi), .inc_x_i(inc_x), .ld_u_i(ld_u), .ld_v_i(ld_v), .ld_y_i(ld_y),
    .en_y_i(en_y), .en_x_i(en_x), .en_u_i(en_u), .en_v_i(en_v), .addr_o(a1), .err_o(e1));

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // check both variants; hi/lo = -1 means default
  task automatic chk_addr(input string req, input int hi, input int lo);
    logic [7:0] h0, h1, l0, l1;
    h0 = (hi < 0) ? 8'h00 : 8'(hi); h1 = (hi < 0) ? 8'hFF : 8'(hi);
    l0 = (lo < 0) ? 8'h00 : 8'(lo); l1 = (lo < 0) ? 8'hFF : 8'(lo);
    #1;
    chk(req, {1'b0, a0}, {1'b0, h0, l0});
    chk(req, {1'b0, a1}, {1'b0, h1, l1});
  endtask

  // one clock of strobes, applied at negedge, released at next negedge
  task automatic pulse(input logic [6:0] s, input logic [7:0] d);
    @(negedge clk);
    {ld_x, ld_xlo, ld_xhi, inc_x, ld_u, ld_v, ld_y} = s;
    bus = d;
    @(negedge clk);
    {ld_x, ld_xlo, ld_xhi, inc_x, ld_u, ld_v, ld_y} = '0;
  endtask

  localparam logic [6:0] S_X = 7'b1000000, S_XLO = 7'b0100000, S_XHI = 7'b0010000,
                         S_INC = 7'b0001000, S_U = 7'b0000100, S_V = 7'b0000010,
                         S_Y = 7'b0000001;

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #25;
    chk_addr("R3 spare cell in reset", -1, -1);
    chk("R9 err low", {16'h0, e0 | e1}, 17'h0);
    @(negedge clk); rst_n = 1'b1;
    en_y = 1; en_x = 1; chk_addr("R9 x,y zero", 0, 0);
    en_x = 0; en_u = 1; chk_addr("R9 u zero", 0, 0);
    en_u = 0; en_v = 1; chk_addr("R9 v zero", 0, 0);
    en_v = 0; en_y = 0;

    for (int i = 0; i < 256; i++) begin
      pulse(S_X, 8'(i));
      pulse(S_U, 8'(i ^ 8'h3C));
      pulse(S_V, 8'(255 - i));
      pulse(S_Y, 8'(i ^ 8'hA5));
      en_x = 1; chk_addr("R2 R4 x", -1, i);
      en_x = 0; en_u = 1; chk_addr("R2 R4 u", -1, i ^ 8'h3C);
      en_u = 0; en_v = 1; en_y = 1; chk_addr("R1 R4 v,y", i ^ 8'hA5, 255 - i);
      en_v = 0; chk_addr("R2 default low", i ^ 8'hA5, -1);
      en_y = 0; chk_addr("R1 R3 default cell", -1, -1);
    end

    // increment and wrap
    pulse(S_Y, 8'h42);
    pulse(S_X, 8'hFE);
    en_y = 1; en_x = 1;
    pulse(S_INC, 8'h00); chk_addr("R5 inc to FF", 8'h42, 8'hFF);
    pulse(S_INC, 8'h00); chk_addr("R5 wrap, y kept", 8'h42, 8'h00);
    @(negedge clk); inc_x = 1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk); chk_addr("R5 streaming inc", 8'h42, i);
    end
    inc_x = 0;

    // nibble loads
    pulse(S_X, 8'h5A);
    pulse(S_XLO, 8'hC3); chk_addr("R6 low nibble", 8'h42, 8'h53);
    pulse(S_XHI, 8'h96); chk_addr("R6 high nibble", 8'h42, 8'h93);
    pulse(S_XLO | S_XHI, 8'h71); chk_addr("R6 both nibbles", 8'h42, 8'h71);

    // load beats increment
    pulse(S_X | S_INC, 8'h10); chk_addr("R7 full load vs inc", 8'h42, 8'h10);
    pulse(S_XHI | S_INC, 8'hE7); chk_addr("R7 nibble load vs inc", 8'h42, 8'hE0);
    pulse(S_XLO | S_INC, 8'h0F); chk_addr("R7 low nibble vs inc", 8'h42, 8'hEF);

    // multiple enables
    pulse(S_U, 8'h21);
    pulse(S_V, 8'h87);
    en_x = 0;
    en_u = 1; en_v = 1; chk_addr("R8 u over v", 8'h42, 8'h21);
    chk("R8 err not yet", {16'h0, e0 | e1}, 17'h0);
    en_x = 1; chk_addr("R8 x over u,v", 8'h42, 8'hEF);
    @(negedge clk); en_x = 0; en_u = 0; en_v = 0;
    chk("R8 err set", {15'h0, e0, e1}, 17'h3);
    repeat (3) @(negedge clk);
    chk("R8 err sticky", {15'h0, e0, e1}, 17'h3);
    rst_n = 0; #1;
    chk("R9 err cleared", {15'h0, e0, e1}, 17'h0);
    en_y = 0; chk_addr("R9 R3 cell after reset", -1, -1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule